// File: doc/BRIEF.md
# Instruction Prefix Parser

This block sits at the front of a variable-length instruction decoder. Instruction bytes arrive one per accepted cycle. The block takes in the legacy prefix bytes that come before an opcode and keeps a per-group record of them. When the first byte that is not a prefix arrives, it emits a one-cycle done pulse. The pulse carries that opcode byte and a registered summary of the instruction's prefixes.

The summary holds the following fields:

- the group-1 choice: lock, repeat or repeat-while-not-equal
- the selected segment override
- the branch-hint reading of the two overloaded segment bytes
- the operand-size and address-size override flags
- the effective operand and address widths for the default segment size given with the opcode
- the number of prefix bytes

The two overloaded bytes (0x2E, 0x3E) are always reported both as a segment override and as a hint. The consumer keeps the hint only when the opcode is a conditional jump.

A run of prefixes longer than the limit ends the instruction early with an error flag. After every done pulse the block starts the next instruction from a clean state.

Top module: `pfx_scan`

## Requirements
- R1: After reset, done, too_long, all summary fields and pfx_cnt are 0, and in_ready is 1.
- R2: A byte accepted while in_valid is 1 that is not one of 0xF0, 0xF2, 0xF3, 0x26, 0x2E, 0x36, 0x3E, 0x64, 0x65, 0x66, 0x67 ends the instruction. done is 1 in the cycle after that byte is accepted and only then, and op_byte equals that byte.
- R3: Group 1 keeps only the last of its bytes. 0xF0 gives lock=1 with rep_kind=0; 0xF3 gives rep_kind=1 with lock=0; 0xF2 gives rep_kind=2 with lock=0; with no group-1 byte, lock=0 and rep_kind=0.
- R4: seg_sel reports the last segment byte with these codes: none=0, 0x26=1, 0x2E=2, 0x36=3, 0x3E=4, 0x64=5, 0x65=6.
- R5: hint is 1 when the last segment byte is 0x2E, 2 when it is 0x3E, and 0 otherwise, including when a later segment byte replaces a 0x2E or 0x3E.
- R6: 0x66 sets opsz_ovr. op32 equals dflt_32 (sampled with the terminating byte) XOR opsz_ovr, and repeating 0x66 flips the width only once.
- R7: 0x67 sets adsz_ovr. ad32 equals dflt_32 XOR adsz_ovr, and repeating 0x67 flips the width only once.
- R8: pfx_cnt counts every prefix byte of the instruction, repeats included, up to MAX_PFX (default 14) with too_long=0.
- R9: The prefix byte that would make the count MAX_PFX+1 ends the instruction with done=1, too_long=1, pfx_cnt=MAX_PFX+1 and op_byte equal to that byte. In that case the summary covers only the first MAX_PFX prefixes.
- R10: After each done pulse, prefix state is cleared, so the next instruction reports only its own prefixes.
- R11: A byte presented while in_valid is 0 is ignored. It neither raises done nor enters the summary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Byte on in_byte is offered |
| in_byte | input | 8 | Instruction stream byte |
| in_ready | output | 1 | Byte can be accepted (always 1) |
| dflt_32 | input | 1 | Default segment size is 32-bit when 1, 16-bit when 0 |
| done | output | 1 | One-cycle pulse: summary and op_byte are valid |
| op_byte | output | 8 | Terminating byte |
| lock | output | 1 | Lock prefix selected |
| rep_kind | output | 2 | 0 none, 1 repeat, 2 repeat-while-not-equal |
| seg_sel | output | 3 | Segment override code |
| hint | output | 2 | 0 none, 1 not taken, 2 taken |
| opsz_ovr | output | 1 | Operand-size override seen |
| adsz_ovr | output | 1 | Address-size override seen |
| op32 | output | 1 | Effective operand size is 32-bit |
| ad32 | output | 1 | Effective address size is 32-bit |
| pfx_cnt | output | $clog2(MAX_PFX+2) | Prefix bytes in the instruction |
| too_long | output | 1 | Prefix run exceeded MAX_PFX |

## Verification
The bench builds the block with the default MAX_PFX of 14. With this value both sides of the limit are reachable with short streams: 14 prefixes followed by an opcode, and a fifteenth prefix that forces the error ending. Both default sizes are applied against the same override bytes, which shows each flip direction. Mixed sequences of same-group bytes show the last-wins rule and how a later segment byte clears a hint.

// File: rtl/pfx_pkg.sv
package pfx_pkg;

  typedef enum logic [1:0] {
    G_LOCKREP = 2'd0,
    G_SEG     = 2'd1,
    G_OSZ     = 2'd2,
    G_ASZ     = 2'd3
  } grp_e;

  // group-1 encoding held in state
  localparam logic [1:0] G1_NONE  = 2'd0;
  localparam logic [1:0] G1_LOCK  = 2'd1;
  localparam logic [1:0] G1_REP   = 2'd2;
  localparam logic [1:0] G1_REPNE = 2'd3;

  // segment codes
  localparam logic [2:0] SEG_NONE = 3'd0;
  localparam logic [2:0] SEG_ES   = 3'd1;
  localparam logic [2:0] SEG_CS   = 3'd2;
  localparam logic [2:0] SEG_SS   = 3'd3;
  localparam logic [2:0] SEG_DS   = 3'd4;
  localparam logic [2:0] SEG_FS   = 3'd5;
  localparam logic [2:0] SEG_GS   = 3'd6;

  localparam logic [1:0] HINT_NONE = 2'd0;
  localparam logic [1:0] HINT_NT   = 2'd1;
  localparam logic [1:0] HINT_TK   = 2'd2;

  typedef struct packed {
    logic       is_pfx;
    grp_e       grp;
    logic [2:0] val;
  } cls_t;

  typedef struct packed {
    logic [1:0] g1;
    logic [2:0] seg;
    logic [1:0] hint;
    logic       osz;
    logic       asz;
  } acc_t;

  function automatic cls_t classify(input logic [7:0] b);
    cls_t c;
    c = '{is_pfx: 1'b1, grp: G_LOCKREP, val: 3'd0};
    case (b)
      8'hF0: begin c.grp = G_LOCKREP; c.val = {1'b0, G1_LOCK};  end
      8'hF3: begin c.grp = G_LOCKREP; c.val = {1'b0, G1_REP};   end
      8'hF2: begin c.grp = G_LOCKREP; c.val = {1'b0, G1_REPNE}; end
      8'h26: begin c.grp = G_SEG;     c.val = SEG_ES; end
      8'h2E: begin c.grp = G_SEG;     c.val = SEG_CS; end
      8'h36: begin c.grp = G_SEG;     c.val = SEG_SS; end
      8'h3E: begin c.grp = G_SEG;     c.val = SEG_DS; end
      8'h64: begin c.grp = G_SEG;     c.val = SEG_FS; end
      8'h65: begin c.grp = G_SEG;     c.val = SEG_GS; end
      8'h66: begin c.grp = G_OSZ;     c.val = 3'd1;   end
      8'h67: begin c.grp = G_ASZ;     c.val = 3'd1;   end
      default: c.is_pfx = 1'b0;
    endcase
    return c;
  endfunction

  function automatic logic [1:0] hint_of(input logic [2:0] seg);
    case (seg)
      SEG_CS:  return HINT_NT;
      SEG_DS:  return HINT_TK;
      default: return HINT_NONE;
    endcase
  endfunction

  function automatic logic [1:0] rep_of(input logic [1:0] g1);
    case (g1)
      G1_REP:   return 2'd1;
      G1_REPNE: return 2'd2;
      default:  return 2'd0;
    endcase
  endfunction

  // an override flips the segment default width
  function automatic logic eff_wide(input logic dflt, input logic ovr);
    return dflt ^ ovr;
  endfunction

endpackage

// File: rtl/pfx_classify.sv
module pfx_classify
  import pfx_pkg::*;
(
  input  logic [7:0] byte_i,
  output cls_t       cls_o
);
  assign cls_o = classify(byte_i);
endmodule

// File: rtl/pfx_accum.sv
module pfx_accum
  import pfx_pkg::*;
#(
  parameter int MAX_PFX = 14,
  localparam int CW = $clog2(MAX_PFX + 2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pfx_take,
  input  logic          clear,
  input  cls_t          cls,
  output acc_t          acc,
  output logic [CW-1:0] cnt,
  output logic          full
);
  localparam logic [CW-1:0] CNT_MAX = CW'(MAX_PFX);

  assign full = (cnt == CNT_MAX);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      acc <= '0;
      cnt <= '0;
    end else if (pfx_take) begin
      cnt <= cnt + 1'b1;
      case (cls.grp)
        G_LOCKREP: acc.g1 <= cls.val[1:0];
        G_SEG: begin
          acc.seg  <= cls.val;
          acc.hint <= hint_of(cls.val);
        end
        G_OSZ: acc.osz <= 1'b1;
        G_ASZ: acc.asz <= 1'b1;
        default: ;
      endcase
    end
  end

  p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_MAX);

  p_hint_seg_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc.hint != HINT_NONE) |-> (acc.seg == SEG_CS || acc.seg == SEG_DS));

endmodule

// File: rtl/pfx_emit.sv
module pfx_emit
  import pfx_pkg::*;
#(
  parameter int MAX_PFX = 14,
  localparam int CW = $clog2(MAX_PFX + 2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          term,
  input  logic          ovf,
  input  logic [7:0]    byte_i,
  input  acc_t          acc,
  input  logic [CW-1:0] cnt,
  input  logic          dflt_32,
  output logic          done,
  output logic [7:0]    op_byte,
  output logic          lock,
  output logic [1:0]    rep_kind,
  output logic [2:0]    seg_sel,
  output logic [1:0]    hint,
  output logic          opsz_ovr,
  output logic          adsz_ovr,
  output logic          op32,
  output logic          ad32,
  output logic [CW-1:0] pfx_cnt,
  output logic          too_long
);
  localparam logic [CW-1:0] CNT_OVF = CW'(MAX_PFX + 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done     <= 1'b0;
      op_byte  <= '0;
      lock     <= 1'b0;
      rep_kind <= '0;
      seg_sel  <= '0;
      hint     <= '0;
      opsz_ovr <= 1'b0;
      adsz_ovr <= 1'b0;
      op32     <= 1'b0;
      ad32     <= 1'b0;
      pfx_cnt  <= '0;
      too_long <= 1'b0;
    end else begin
      done <= term;
      if (term) begin
        op_byte  <= byte_i;
        lock     <= (acc.g1 == G1_LOCK);
        rep_kind <= rep_of(acc.g1);
        seg_sel  <= acc.seg;
        hint     <= acc.hint;
        opsz_ovr <= acc.osz;
        adsz_ovr <= acc.asz;
        op32     <= eff_wide(dflt_32, acc.osz);
        ad32     <= eff_wide(dflt_32, acc.asz);
        pfx_cnt  <= ovf ? CNT_OVF : cnt;
        too_long <= ovf;
      end
    end
  end

  p_g1_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({lock, rep_kind == 2'd1, rep_kind == 2'd2}) && rep_kind != 2'd3);

  p_ovf_cnt_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && too_long) |-> (pfx_cnt == CNT_OVF));

  p_opsz_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !opsz_ovr) |-> (op32 == $past(dflt_32)));

  p_adsz_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !adsz_ovr) |-> (ad32 == $past(dflt_32)));

endmodule

// File: rtl/pfx_scan.sv
module pfx_scan
  import pfx_pkg::*;
#(
  parameter int MAX_PFX = 14,
  localparam int CW = $clog2(MAX_PFX + 2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [7:0]    in_byte,
  output logic          in_ready,
  input  logic          dflt_32,
  output logic          done,
  output logic [7:0]    op_byte,
  output logic          lock,
  output logic [1:0]    rep_kind,
  output logic [2:0]    seg_sel,
  output logic [1:0]    hint,
  output logic          opsz_ovr,
  output logic          adsz_ovr,
  output logic          op32,
  output logic          ad32,
  output logic [CW-1:0] pfx_cnt,
  output logic          too_long
);
  cls_t          cls;
  acc_t          acc;
  logic [CW-1:0] acc_cnt;
  logic          acc_full;

  // named events
  logic ev_take, ev_pfx, ev_ovf, ev_term, ev_absorb;

  assign in_ready  = 1'b1;
  assign ev_take   = in_valid && in_ready;
  assign ev_pfx    = ev_take && cls.is_pfx;
  assign ev_ovf    = ev_pfx && acc_full;
  assign ev_term   = (ev_take && !cls.is_pfx) || ev_ovf;
  assign ev_absorb = ev_pfx && !ev_ovf;

  pfx_classify u_cls (
    .byte_i (in_byte),
    .cls_o  (cls)
  );

  pfx_accum #(.MAX_PFX(MAX_PFX)) u_acc (
    .clk      (clk),
    .rst_n    (rst_n),
    .pfx_take (ev_absorb),
    .clear    (ev_term),
    .cls      (cls),
    .acc      (acc),
    .cnt      (acc_cnt),
    .full     (acc_full)
  );

  pfx_emit #(.MAX_PFX(MAX_PFX)) u_emit (
    .clk      (clk),
    .rst_n    (rst_n),
    .term     (ev_term),
    .ovf      (ev_ovf),
    .byte_i   (in_byte),
    .acc      (acc),
    .cnt      (acc_cnt),
    .dflt_32  (dflt_32),
    .done     (done),
    .op_byte  (op_byte),
    .lock     (lock),
    .rep_kind (rep_kind),
    .seg_sel  (seg_sel),
    .hint     (hint),
    .opsz_ovr (opsz_ovr),
    .adsz_ovr (adsz_ovr),
    .op32     (op32),
    .ad32     (ad32),
    .pfx_cnt  (pfx_cnt),
    .too_long (too_long)
  );

  p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (acc_cnt == '0 && acc == '0));

  p_done_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(in_valid));

  p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!done && $stable(acc_cnt)));

endmodule

// File: tb/sim_pfx_scan.sv
module sim_pfx_scan;
  localparam int MAXP = 14;
  localparam int CW   = $clog2(MAXP + 2);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic dflt_32 = 1'b1;
  logic in_ready, done, lock, opsz_ovr, adsz_ovr, op32, ad32, too_long;
  logic [7:0] op_byte;
  logic [1:0] rep_kind, hint;
  logic [2:0] seg_sel;
  logic [CW-1:0] pfx_cnt;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  pfx_scan #(.MAX_PFX(MAXP)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
    .in_ready(in_ready), .dflt_32(dflt_32), .done(done), .op_byte(op_byte),
    .lock(lock), .rep_kind(rep_kind), .seg_sel(seg_sel), .hint(hint),
    .opsz_ovr(opsz_ovr), .adsz_ovr(adsz_ovr), .op32(op32), .ad32(ad32),
    .pfx_cnt(pfx_cnt), .too_long(too_long)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // called at a negedge; returns at the next negedge
  task automatic push(input logic [7:0] b);
    in_valid = 1'b1;
    in_byte  = b;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic chk_sum(input string tag, input int op, input int lk,
                         input int rp, input int sg, input int hn,
                         input int cnt, input int tl);
    chk({tag, " done"}, done, 1);
    chk({tag, " op_byte"}, op_byte, op);
    chk({tag, " lock"}, lock, lk);
    chk({tag, " rep_kind"}, rep_kind, rp);
    chk({tag, " seg_sel"}, seg_sel, sg);
    chk({tag, " hint"}, hint, hn);
    chk({tag, " pfx_cnt"}, pfx_cnt, cnt);
    chk({tag, " too_long"}, too_long, tl);
  endtask

  task automatic t_reset;
    chk("R1 done", done, 0);
    chk("R1 in_ready", in_ready, 1);
    chk("R1 cnt", pfx_cnt, 0);
    chk("R1 fields", {lock, rep_kind, seg_sel, hint, opsz_ovr, adsz_ovr, too_long}, 0);
  endtask

  task automatic t_plain;
    push(8'h90);
    chk_sum("R2 plain", 8'h90, 0, 0, 0, 0, 0, 0);
    @(negedge clk);
    chk("R2 single pulse", done, 0);
  endtask

  task automatic t_group1;
    push(8'hF0); chk("R2 no done on prefix", done, 0);
    push(8'h87);
    chk_sum("R3 lock", 8'h87, 1, 0, 0, 0, 1, 0);
    push(8'hF0); push(8'hF3); push(8'hA5);
    chk_sum("R3 rep after lock", 8'hA5, 0, 1, 0, 0, 2, 0);
    push(8'hF3); push(8'hF2); push(8'hA6);
    chk_sum("R3 repne wins", 8'hA6, 0, 2, 0, 0, 2, 0);
  endtask

  task automatic t_seg;
    push(8'h26); push(8'h8B);
    chk_sum("R4 es", 8'h8B, 0, 0, 1, 0, 1, 0);
    push(8'h64); push(8'h65); push(8'h36); push(8'h8B);
    chk_sum("R4 ss last", 8'h8B, 0, 0, 3, 0, 3, 0);
    push(8'h65); push(8'h8B);
    chk_sum("R4 gs", 8'h8B, 0, 0, 6, 0, 1, 0);
    push(8'h64); push(8'h8B);
    chk_sum("R4 fs", 8'h8B, 0, 0, 5, 0, 1, 0);
  endtask

  task automatic t_hint;
    push(8'h2E); push(8'h74);
    chk_sum("R5 not taken", 8'h74, 0, 0, 2, 1, 1, 0);
    push(8'h3E); push(8'h75);
    chk_sum("R5 taken", 8'h75, 0, 0, 4, 2, 1, 0);
    push(8'h3E); push(8'h26); push(8'h75);
    chk_sum("R5 hint replaced", 8'h75, 0, 0, 1, 0, 2, 0);
  endtask

  task automatic t_sizes;
    dflt_32 = 1'b1;
    push(8'h66); push(8'h66); push(8'h89);
    chk("R6 ovr", opsz_ovr, 1); chk("R6 op32 32->16 once", op32, 0);
    chk("R7 ad32 unchanged", ad32, 1); chk("R8 cnt repeats", pfx_cnt, 2);
    push(8'h66);
    dflt_32 = 1'b0;
    push(8'h89);
    chk("R6 op32 16->32", op32, 1); chk("R7 ad32 16", ad32, 0);
    push(8'h67); push(8'h67); push(8'h8D);
    chk("R7 ovr", adsz_ovr, 1); chk("R7 ad32 16->32 once", ad32, 1);
    chk("R6 no ovr", opsz_ovr, 0); chk("R6 op32 16", op32, 0);
    dflt_32 = 1'b1;
    push(8'h67); push(8'h8D);
    chk("R7 ad32 32->16", ad32, 0);
  endtask

  task automatic t_count;
    for (int i = 0; i < MAXP; i++) push(8'hF0);
    chk("R8 no done at limit", done, 0);
    push(8'h90);
    chk_sum("R8 limit", 8'h90, 1, 0, 0, 0, MAXP, 0);
  endtask

  task automatic t_overflow;
    for (int i = 0; i < MAXP; i++) push(8'hF0);
    push(8'h66);
    chk_sum("R9 overflow", 8'h66, 1, 0, 0, 0, MAXP + 1, 1);
    chk("R9 excess not absorbed", opsz_ovr, 0);
    push(8'h90);
    chk_sum("R10 clean after error", 8'h90, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_clear;
    push(8'hF3); push(8'h2E); push(8'h66); push(8'h67); push(8'hAB);
    chk_sum("R10 full set", 8'hAB, 0, 1, 2, 1, 4, 0);
    push(8'hC3);
    chk_sum("R10 cleared", 8'hC3, 0, 0, 0, 0, 0, 0);
    chk("R10 osz cleared", opsz_ovr, 0);
    chk("R10 asz cleared", adsz_ovr, 0);
  endtask

  task automatic t_idle;
    in_valid = 1'b0;
    in_byte  = 8'hF0;
    @(negedge clk);
    chk("R11 no done", done, 0);
    in_byte = 8'h90;
    @(negedge clk);
    chk("R11 no done 2", done, 0);
    push(8'hC3);
    chk_sum("R11 idle ignored", 8'hC3, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_plain;
    t_group1;
    t_seg;
    t_hint;
    t_sizes;
    t_count;
    t_overflow;
    t_clear;
    t_idle;
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule